// File: doc/BRIEF.md
# Indirect Flash Read Engine

The block moves a host-requested run of bytes from a serial flash into an on-chip word FIFO without host involvement per byte. Software programs a start address, a byte count, an opcode, the data lane width, the number of address bytes and a dummy-cycle count, then sets a start bit. The engine lowers chip-select, shifts out the opcode and address on a single lane, waits the dummy cycles, and then takes data bytes at a rate set by the lane width. Bytes are packed into FIFO words and the host drains them through a pop port while the transfer is still running.

The FIFO is bounded by a partition register that reset loads with half the FIFO depth. When the fill level reaches the partition the engine holds chip-select low and waits for space. The host sees the fill level in FIFO words, and a done flag that stays set until the host writes a one to it. A cancel bit aborts a transfer at any point and empties the FIFO. The flash pins are modelled as a byte source: the engine pulses a take strobe at the end of each data byte period and samples the byte presented to it.

Top module: `qrd_engine`

## Requirements
- R1: After reset the control register (index 0) reads 0, the level register (index 4) reads 0, the partition register (index 5) reads DEPTH/2 and `fl_cs_n` is high.
- R2: After start, `fl_tx_valid` is high with `fl_cs_n` low for 8 cycles per command byte; the bytes are the opcode (instruction bits [7:0]) then the address, most significant byte first, with the address byte count equal to instruction bits [16:15] plus one.
- R3: The number of cycles given in instruction bits [14:10] elapses between the last command cycle and the first data byte period.
- R4: Instruction bits [9:8] select the data lanes: 0 single, 1 dual, 2 quad, 3 octal, giving 8, 4, 2 or 1 cycles per data byte; `fl_rx_take` pulses in the last cycle of each byte period, never during the command phase.
- R5: Data bytes are packed little-endian into 32-bit FIFO words in arrival order; a final partial word is padded with zero bytes.
- R6: The level register reports the FIFO occupancy in words in bits [15:0]; bits [31:16] read zero.
- R7: When the level equals the partition the engine stops taking bytes while keeping `fl_cs_n` low, and resumes once the host pops a word.
- R8: The partition register is writable and caps the FIFO occupancy at the written value.
- R9: After the last byte is stored, `fl_cs_n` goes high for one cycle with busy (control bit 2) still set; in the following cycle busy clears and done (control bit 5) sets.
- R10: Writing 1 to control bit 5 clears done; writing 0 to it leaves done unchanged.
- R11: Writing 1 to control bit 1 ends the transfer: on the next cycle busy is clear, `fl_cs_n` is high, the level is 0 and done is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pop | input | 1 | Remove the head FIFO word |
| pop_data | output | 32 | Head FIFO word |
| fl_cs_n | output | 1 | Flash chip-select, active low |
| fl_tx_valid | output | 1 | Command byte on the single lane |
| fl_tx_byte | output | 8 | Current command byte |
| fl_rx_take | output | 1 | Data byte sampled this cycle |
| fl_rx_byte | input | 8 | Data byte from the flash model |

## Verification
The checks assume the host changes the partition register only while the engine is idle and the FIFO is empty, so that the level can never exceed the partition; every scenario reprograms it between transfers only. They also assume the flash model presents a valid byte whenever the take strobe is high, which the bench's byte source does at all times. Done-clear checks apply only when the engine is idle, and the bench issues its clears between transfers.

// File: rtl/qrd_pkg.sv
// Shared register indices, control bit positions and sequencer states.
// Assumes a 3-bit register index space.
package qrd_pkg;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_ADDR  = 3'd1;
    localparam logic [2:0] REG_COUNT = 3'd2;
    localparam logic [2:0] REG_INSTR = 3'd3;
    localparam logic [2:0] REG_LEVEL = 3'd4;
    localparam logic [2:0] REG_PART  = 3'd5;

    localparam int CTRL_GO    = 0;
    localparam int CTRL_ABORT = 1;
    localparam int CTRL_BUSY  = 2;
    localparam int CTRL_DONE  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DUMMY,
        ST_DATA,
        ST_FIN
    } qrd_state_e;

    // Cycles per data byte minus one for a lane code.
    function automatic logic [4:0] byte_cycles_m1(input logic [1:0] lane);
        case (lane)
            2'd0:    return 5'd7;
            2'd1:    return 5'd3;
            2'd2:    return 5'd1;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/qrd_fifo.sv
// Word FIFO with flush. Assumes DEPTH is a power of two and that the
// writer never pushes when full (pushes when full are dropped).
module qrd_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  logic [W-1:0]              wdata,
    input  logic                      pop,
    output logic [W-1:0]              head,
    output logic [$clog2(DEPTH):0]    level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != (AW+1)'(DEPTH));
    assign do_pop  = pop && (cnt != '0);
    assign head    = mem[rp];
    assign level   = cnt;

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/qrd_packer.sv
// Packs bytes little-endian into words; emits a word when full or on the
// last byte of a transfer, upper bytes zero. Assumes WB >= 2.
module qrd_packer #(
    parameter int WB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              vld,
    input  logic [7:0]        byte_in,
    input  logic              last,
    output logic              push,
    output logic [8*WB-1:0]   word
);
    localparam int FW = $clog2(WB);

    logic [8*WB-1:0] acc;
    logic [FW-1:0]   fill;

    assign push = vld && ((fill == FW'(WB-1)) || last);
    assign word = acc | ((8*WB)'(byte_in) << {fill, 3'b000});

    // Accumulate bytes until a word is emitted.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc  <= '0;
            fill <= '0;
        end else if (vld) begin
            if (push) begin
                acc  <= '0;
                fill <= '0;
            end else begin
                acc  <= word;
                fill <= fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qrd_seq.sv
// Transfer sequencer: command bytes on one lane (8 cycles each), dummy
// cycles, then data byte periods sized by the lane code, then one cycle
// with chip-select released. Latches the setup at start.
module qrd_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic [7:0]       opcode,
    input  logic [31:0]      addr,
    input  logic [1:0]       adr_m1,
    input  logic [4:0]       dummy,
    input  logic [1:0]       lane,
    input  logic [CNT_W-1:0] count,
    input  logic             space_ok,
    output logic             busy,
    output logic             cs_n,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             take,
    output logic             last,
    output logic             fin
);
    import qrd_pkg::*;

    qrd_state_e       st;
    logic [4:0]       cyc;
    logic [2:0]       bidx, nb_m1;
    logic [39:0]      sr;
    logic [1:0]       lane_q;
    logic [4:0]       dummy_q;
    logic [CNT_W-1:0] remain;
    logic [1:0]       sh;
    logic [4:0]       cpb_m1;

    assign sh       = 2'd3 - adr_m1;
    assign cpb_m1   = byte_cycles_m1(lane_q);
    assign busy     = (st != ST_IDLE);
    assign cs_n     = !((st == ST_CMD) || (st == ST_DUMMY) || (st == ST_DATA));
    assign tx_valid = (st == ST_CMD);
    assign tx_byte  = sr[39:32];
    assign take     = (st == ST_DATA) && (cyc == cpb_m1) && space_ok && !abort;
    assign last     = take && (remain == CNT_W'(1));
    assign fin      = (st == ST_FIN) && !abort;

    // Phase state machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cyc     <= '0;
            bidx    <= '0;
            nb_m1   <= '0;
            sr      <= '0;
            lane_q  <= '0;
            dummy_q <= '0;
            remain  <= '0;
        end else if (abort) begin
            st  <= ST_IDLE;
            cyc <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    sr      <= {opcode, addr << {sh, 3'b000}};
                    nb_m1   <= {1'b0, adr_m1} + 3'd1;
                    bidx    <= '0;
                    cyc     <= '0;
                    lane_q  <= lane;
                    dummy_q <= dummy;
                    remain  <= count;
                    st      <= ST_CMD;
                end
                ST_CMD: if (cyc == 5'd7) begin
                    cyc  <= '0;
                    sr   <= sr << 8;
                    bidx <= bidx + 3'd1;
                    if (bidx == nb_m1) begin
                        if (dummy_q != '0)      st <= ST_DUMMY;
                        else if (remain != '0)  st <= ST_DATA;
                        else                    st <= ST_FIN;
                    end
                end else begin
                    cyc <= cyc + 5'd1;
                end
                ST_DUMMY: if (cyc == dummy_q - 5'd1) begin
                    cyc <= '0;
                    st  <= (remain != '0) ? ST_DATA : ST_FIN;
                end else begin
                    cyc <= cyc + 5'd1;
                end
                ST_DATA: if (cyc == cpb_m1) begin
                    if (space_ok) begin
                        cyc    <= '0;
                        remain <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) st <= ST_FIN;
                    end
                end else begin
                    cyc <= cyc + 5'd1;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qrd_engine.sv
// Indirect flash read engine top: register file, sequencer, byte packer
// and word FIFO. Assumes the partition is changed only while idle and
// empty, and WB*8 equals 32 for the pop port.
module qrd_engine #(
    parameter int DEPTH = 16,
    parameter int WB    = 4,
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        pop,
    output logic [31:0] pop_data,
    output logic        fl_cs_n,
    output logic        fl_tx_valid,
    output logic [7:0]  fl_tx_byte,
    output logic        fl_rx_take,
    input  logic [7:0]  fl_rx_byte
);
    import qrd_pkg::*;

    localparam int LVL_W = $clog2(DEPTH) + 1;
    localparam int DW    = 8 * WB;

    logic [31:0]      addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [16:0]      instr_q;
    logic [LVL_W-1:0] part_q, lvl;
    logic             done_q, busy, fin, last, push, go, abort, ctrl_wr;
    logic [DW-1:0]    word, head;

    assign ctrl_wr = reg_wr && (reg_addr == REG_CTRL);
    assign abort   = ctrl_wr && reg_wdata[CTRL_ABORT];
    assign go      = ctrl_wr && reg_wdata[CTRL_GO] && !busy;

    // Setup registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            instr_q <= '0;
            part_q  <= LVL_W'(DEPTH / 2);
        end else if (reg_wr) begin
            case (reg_addr)
                REG_ADDR:  addr_q  <= reg_wdata;
                REG_COUNT: cnt_q   <= reg_wdata[CNT_W-1:0];
                REG_INSTR: instr_q <= reg_wdata[16:0];
                REG_PART:  part_q  <= (reg_wdata[15:0] > 16'(DEPTH)) ?
                                      LVL_W'(DEPTH) : reg_wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    // Done flag: set on completion, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                             done_q <= 1'b0;
        else if (fin)                           done_q <= 1'b1;
        else if (ctrl_wr && reg_wdata[CTRL_DONE]) done_q <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_BUSY] = busy;
                reg_rdata[CTRL_DONE] = done_q;
            end
            REG_ADDR:  reg_rdata = addr_q;
            REG_COUNT: reg_rdata = 32'(cnt_q);
            REG_INSTR: reg_rdata = 32'(instr_q);
            REG_LEVEL: reg_rdata = 32'(lvl);
            REG_PART:  reg_rdata = 32'(part_q);
            default:   reg_rdata = '0;
        endcase
    end

    qrd_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort),
        .opcode(instr_q[7:0]), .addr(addr_q), .adr_m1(instr_q[16:15]),
        .dummy(instr_q[14:10]), .lane(instr_q[9:8]), .count(cnt_q),
        .space_ok(lvl < part_q), .busy(busy), .cs_n(fl_cs_n),
        .tx_valid(fl_tx_valid), .tx_byte(fl_tx_byte), .take(fl_rx_take),
        .last(last), .fin(fin)
    );

    qrd_packer #(.WB(WB)) u_pack (
        .clk(clk), .rst_n(rst_n), .flush(abort), .vld(fl_rx_take),
        .byte_in(fl_rx_byte), .last(last), .push(push), .word(word)
    );

    qrd_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(abort), .push(push), .wdata(word),
        .pop(pop), .head(head), .level(lvl)
    );

    assign pop_data = 32'(head);
endmodule

// File: rtl/qrd_engine_chk.sv
// Protocol checker for qrd_engine, attached by bind. Assumes the host
// alters the partition only while idle with an empty FIFO.
module qrd_engine_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             fl_cs_n,
    input logic             fl_tx_valid,
    input logic             fl_rx_take,
    input logic             busy,
    input logic             done_q,
    input logic [LVL_W-1:0] lvl,
    input logic [LVL_W-1:0] part_q
);
    AST_TX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        fl_tx_valid |-> !fl_cs_n); // R2
    AST_TAKE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rx_take |-> (!fl_cs_n && !fl_tx_valid)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rx_take |-> (lvl < part_q)); // R7
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (fl_cs_n && $past(fl_cs_n) && !busy)); // R9
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[5] && !busy) |=> !done_q); // R10
    AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[1]) |=> (!busy && fl_cs_n && lvl == '0)); // R11
endmodule

bind qrd_engine qrd_engine_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fl_cs_n(fl_cs_n), .fl_tx_valid(fl_tx_valid),
    .fl_rx_take(fl_rx_take), .busy(busy), .done_q(done_q), .lvl(lvl),
    .part_q(part_q)
);

// File: tb/sim_qrd_engine.sv
// Directed bench for qrd_engine: one task per scenario.
module sim_qrd_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic        fl_cs_n, fl_tx_valid, fl_rx_take;
    logic [7:0]  fl_tx_byte, fl_rx_byte;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qrd_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop),
        .pop_data(pop_data), .fl_cs_n(fl_cs_n), .fl_tx_valid(fl_tx_valid),
        .fl_tx_byte(fl_tx_byte), .fl_rx_take(fl_rx_take), .fl_rx_byte(fl_rx_byte)
    );

    // Flash byte source: byte k of the stream is 3*k + 0x11.
    logic [7:0] src_idx;
    always_ff @(posedge clk) begin
        if (!rst_n)          src_idx <= '0;
        else if (fl_rx_take) src_idx <= src_idx + 8'd1;
    end
    assign fl_rx_byte = src_idx * 8'd3 + 8'h11;

    // Monitor of command bytes and take timing.
    logic       mon_on = 1'b0;
    logic       seen = 1'b0;
    int         tcnt = 0, ntake = 0, ntx = 0, txcyc = 0;
    int         take_t [128];
    logic [7:0] tx_log [16];

    always @(negedge clk) begin
        if (mon_on) begin
            if (fl_tx_valid) begin
                if ((txcyc % 8) == 0 && ntx < 16) begin
                    tx_log[ntx] = fl_tx_byte;
                    ntx++;
                end
                txcyc++;
            end
            if (fl_tx_valid || seen) begin
                seen = 1'b1;
                if (fl_rx_take && ntake < 128) begin
                    take_t[ntake] = tcnt;
                    ntake++;
                end
                tcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(3'd0, d);
            if (!d[2]) break;
        end
    endtask

    task automatic pop_word(output logic [31:0] w);
        @(negedge clk);
        w = pop_data;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int base, input int cnt, input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            int k = w * 4 + b;
            if (k < cnt) r[8*b +: 8] = 8'((base + k) * 3 + 8'h11);
        end
        return r;
    endfunction

    task automatic setup(input logic [31:0] a, input int cnt, input logic [7:0] op,
                         input logic [1:0] lane, input logic [4:0] dum,
                         input logic [1:0] am1, output int base);
        reg_write(3'd1, a);
        reg_write(3'd2, 32'(cnt));
        reg_write(3'd3, {15'd0, am1, dum, lane, op});
        mon_on = 1'b0; seen = 1'b0; tcnt = 0; ntake = 0; ntx = 0; txcyc = 0;
        base = int'(src_idx);
        mon_on = 1'b1;
        reg_write(3'd0, 32'h1);
    endtask

    task automatic drain_check(input int base, input int cnt, input string tag);
        logic [31:0] w;
        for (int i = 0; i < (cnt + 3) / 4; i++) begin
            pop_word(w);
            chk(w == exp_word(base, cnt, i), tag, w, exp_word(base, cnt, i));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        reg_read(3'd0, d); chk(d == 32'h0, "R1 ctrl", d, 32'h0);
        reg_read(3'd4, d); chk(d == 32'h0, "R1 level", d, 32'h0);
        reg_read(3'd5, d); chk(d == 32'd8, "R1 R8 partition", d, 32'd8);
        chk(fl_cs_n == 1'b1, "R1 cs_n", 32'(fl_cs_n), 32'd1);
    endtask

    task automatic t_single();
        int base;
        logic [31:0] d;
        setup(32'h0012_3456, 6, 8'h03, 2'd0, 5'd0, 2'd2, base);
        wait_idle();
        chk(ntx == 4, "R2 cmd byte count", 32'(ntx), 32'd4);
        chk(tx_log[0] == 8'h03, "R2 opcode", 32'(tx_log[0]), 32'h03);
        chk({tx_log[1], tx_log[2], tx_log[3]} == 24'h123456, "R2 address order",
            32'({tx_log[1], tx_log[2], tx_log[3]}), 32'h123456);
        chk(txcyc == 32, "R2 cmd cycles", 32'(txcyc), 32'd32);
        chk(take_t[0] == 39, "R4 first take single", 32'(take_t[0]), 32'd39);
        chk(take_t[1] - take_t[0] == 8, "R4 single spacing", 32'(take_t[1] - take_t[0]), 32'd8);
        reg_read(3'd4, d); chk(d == 32'd2, "R6 level in words", d, 32'd2);
        reg_read(3'd0, d); chk(d == 32'h20, "R9 done set busy clear", d, 32'h20);
        drain_check(base, 6, "R5 packing single");
    endtask

    task automatic t_done_clear();
        logic [31:0] d;
        reg_write(3'd0, 32'h0);
        reg_read(3'd0, d); chk(d[5] == 1'b1, "R10 write zero keeps done", d, 32'h20);
        reg_write(3'd0, 32'h20);
        reg_read(3'd0, d); chk(d[5] == 1'b0, "R10 write one clears done", d, 32'h0);
    endtask

    task automatic t_quad_dummy();
        int base;
        logic [31:0] d;
        setup(32'hA1B2_C3D4, 8, 8'h6B, 2'd2, 5'd8, 2'd3, base);
        wait_idle();
        chk(ntx == 5, "R2 four-byte address count", 32'(ntx), 32'd5);
        chk({tx_log[1], tx_log[2], tx_log[3], tx_log[4]} == 32'hA1B2C3D4, "R2 4-byte address",
            {tx_log[1], tx_log[2], tx_log[3], tx_log[4]}, 32'hA1B2C3D4);
        chk(take_t[0] == 49, "R3 dummy before data", 32'(take_t[0]), 32'd49);
        chk(take_t[1] - take_t[0] == 2, "R4 quad spacing", 32'(take_t[1] - take_t[0]), 32'd2);
        reg_read(3'd4, d); chk(d[31:16] == 16'd0, "R6 upper half zero", d, 32'd2);
        drain_check(base, 8, "R5 packing quad");
        reg_write(3'd0, 32'h20);
    endtask

    task automatic t_lane(input logic [1:0] lane, input int dum, input int cnt);
        int base;
        int cpb = 8 >> lane;
        setup(32'h0000_4000, cnt, 8'h0B, lane, 5'(dum), 2'd2, base);
        wait_idle();
        chk(take_t[0] == 32 + dum + cpb - 1, "R4 R3 first take", 32'(take_t[0]),
            32'(32 + dum + cpb - 1));
        chk(take_t[1] - take_t[0] == cpb, "R4 lane spacing", 32'(take_t[1] - take_t[0]), 32'(cpb));
        drain_check(base, cnt, "R5 packing lane");
        reg_write(3'd0, 32'h20);
    endtask

    task automatic t_stall();
        int base;
        logic [31:0] d, w;
        reg_write(3'd5, 32'd2);
        reg_read(3'd5, d); chk(d == 32'd2, "R8 partition write", d, 32'd2);
        setup(32'h0000_0100, 16, 8'h0B, 2'd3, 5'd0, 2'd2, base);
        repeat (120) @(negedge clk);
        reg_read(3'd4, d); chk(d == 32'd2, "R7 R8 level capped", d, 32'd2);
        reg_read(3'd0, d); chk(d[2] == 1'b1, "R7 busy while stalled", d, 32'h4);
        chk(fl_cs_n == 1'b0, "R7 cs held low", 32'(fl_cs_n), 32'd0);
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 200; j++) begin
                @(negedge clk);
                reg_read(3'd4, d);
                if (d != 0) break;
            end
            pop_word(w);
            chk(w == exp_word(base, 16, i), "R7 resumed data", w, exp_word(base, 16, i));
        end
        wait_idle();
        chk(ntake == 16, "R7 all bytes taken", 32'(ntake), 32'd16);
        reg_read(3'd0, d); chk(d == 32'h20, "R9 done after stall", d, 32'h20);
        reg_write(3'd0, 32'h20);
        reg_write(3'd5, 32'd8);
    endtask

    task automatic t_cancel();
        int base, nt;
        logic [31:0] d;
        setup(32'h0000_0200, 40, 8'h03, 2'd0, 5'd0, 2'd2, base);
        repeat (100) @(negedge clk);
        reg_write(3'd0, 32'h2);
        reg_read(3'd0, d); chk(d == 32'h0, "R11 busy and done clear", d, 32'h0);
        reg_read(3'd4, d); chk(d == 32'h0, "R11 FIFO flushed", d, 32'h0);
        chk(fl_cs_n == 1'b1, "R11 cs released", 32'(fl_cs_n), 32'd1);
        nt = ntake;
        repeat (30) @(negedge clk);
        chk(ntake == nt, "R11 no takes after cancel", 32'(ntake), 32'(nt));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_done_clear();
        t_quad_dummy();
        t_lane(2'd3, 4, 4);
        t_lane(2'd1, 0, 3);
        t_stall();
        t_cancel();
        finish_run();
    end
endmodule